// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a differential successive-approximation converter. A falling chip select starts a sampling window of a fixed number of serial clocks. The block then runs a binary search: each clock it reads a one-bit comparator, fixes one result bit, and drives the next trial code to the capacitive DAC. Each bit is sent out on the serial data output in the same cycle its decision is registered, most significant bit first, so a host can shift the result while the search is still running.

Codes are two's complement. The first trial is the zero code, and that decision gives the sign bit. Chip select high stops the block at once and returns it to idle. Any bits decided before the abort stay in the result as a coarser reading. Resolution is set by a parameter to 12 or 10 bits. The analog comparator, the hold capacitors and the DAC sit outside the block. The comparator input is 1 when the held differential input is at or above the level of the current trial code.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, `sampling`, `converting`, `done` and `bit_vld` are low and `result` is all zeros.
- R2: A clock edge that samples `cs_n` low, after an earlier edge sampled it high, starts a conversion. `sampling` is then high for exactly ACQ_CYCLES cycles, and `converting` rises on the next edge.
- R3: The first trial code shown on `dac_code` during conversion is zero, the midpoint of the signed range. The second trial is +1/4 of full scale (12-bit: 0x400) when the sign bit resolved as 0, and -1/4 of full scale (12-bit: 0xC00) when it resolved as 1.
- R4: Given an ideal comparator (`cmp_hi` = held >= `dac_code`, signed), `result` equals the held two's-complement code. This includes most negative (0x800), zero (0x000) and most positive (0x7FF).
- R5: One bit per clock appears on `bit_out`, qualified by `bit_vld`, most significant bit first. The NBITS bits together equal `result`.
- R6: `done` is high for exactly one cycle. It is seen after the (ACQ_CYCLES+NBITS+1)-th clock edge, counting the start edge as the first, and in that cycle `bit_vld` carries the last bit.
- R7: Any clock edge that samples `cs_n` high during sampling, conversion or hold sends the block to idle. On the next cycle `sampling` and `converting` are low, and no `done` follows.
- R8: After an abort following K decisions, `result` holds the K decided upper bits. Every undecided lower bit reads 0.
- R9: If `cs_n` stays low after `done`, no new conversion starts until `cs_n` has been high and then low again.
- R10: With NBITS = 10, a conversion yields the 10-bit two's-complement code in 10 decision clocks.
- R11: An abort during sampling leaves `result` at zero. The result of any earlier conversion is cleared at the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state moves on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low; falling edge starts, high aborts |
| cmp_hi | input | 1 | Comparator: 1 when held input is at or above the trial level |
| sampling | output | 1 | High during the acquisition window |
| converting | output | 1 | High while bits are being decided |
| dac_code | output | NBITS | Trial code for the DAC, two's complement |
| bit_out | output | 1 | Most recently decided result bit |
| bit_vld | output | 1 | Qualifies `bit_out` for one cycle |
| result | output | NBITS | Decided bits, two's complement, undecided bits zero |
| done | output | 1 | One-cycle pulse after the least significant bit |

## Verification
The hardest case to reach is an abort after an exact number of decisions. The edge that samples `cs_n` high must be the one that would have made decision K+1. The bench drives this by counting `bit_vld` at each falling clock edge and raising `cs_n` in the same half-cycle as the K-th bit, so the next rising edge stops the search. Full-scale extremes and a sign flip show whether the signed comparator sense and the sign inversion agree. A run that holds `cs_n` low well past `done` shows that the block does not restart on its own.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACQ  = 2'd1,
        PH_CONV = 2'd2,
        PH_HOLD = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e ph;
        logic   done;
    } ctl_s;

endpackage

// File: rtl/sar_cs_edge.sv
module sar_cs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = cs_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    // a start needs a high sample followed by a low sample
    assign fall = prev_q & ~cs_n;

endmodule

// File: rtl/sar_acq_timer.sv
module sar_acq_timer #(
    parameter int ACQ_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expire
);
    localparam int CW = (ACQ_CYCLES > 1) ? $clog2(ACQ_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(ACQ_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = '0;
        else if (run && cnt_q != LAST)
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = run && (cnt_q == LAST);

    // R2: while the window is open and not yet over, the count advances by one
    a_r2_acq_count: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !expire && !load) |=> (cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/sar_search.sv
module sar_search #(
    parameter int NBITS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             init,
    input  logic             step,
    input  logic             cmp_hi,
    output logic [NBITS-1:0] dac_code,
    output logic             bit_out,
    output logic             bit_vld,
    output logic [NBITS-1:0] result,
    output logic             last
);
    localparam int IW = $clog2(NBITS);
    localparam logic [IW-1:0]    TOP  = IW'(NBITS - 1);
    localparam logic [NBITS-1:0] SIGN = {1'b1, {(NBITS-1){1'b0}}};

    typedef struct packed {
        logic [NBITS-1:0] trial;   // offset-binary trial code
        logic [NBITS-1:0] res;     // two's-complement decided bits
        logic [IW-1:0]    idx;     // bit under trial
        logic             bitv;
        logic             vld;
    } srch_s;

    srch_s s_d, s_q;
    logic  tw;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        tw      = (s_q.idx == TOP) ? ~cmp_hi : cmp_hi;
        if (clear)
            s_d.res = '0;
        if (init) begin
            s_d.trial = SIGN;
            s_d.idx   = TOP;
        end
        if (step) begin
            s_d.res[s_q.idx]   = tw;
            s_d.bitv           = tw;
            s_d.vld            = 1'b1;
            s_d.trial[s_q.idx] = cmp_hi;
            if (s_q.idx != '0) begin
                s_d.trial[s_q.idx - IW'(1)] = 1'b1;
                s_d.idx                     = s_q.idx - IW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dac_code = s_q.trial ^ SIGN;
    assign bit_out  = s_q.bitv;
    assign bit_vld  = s_q.vld;
    assign result   = s_q.res;
    assign last     = step && (s_q.idx == '0);

    // R3: the bit under trial is set when it is decided
    a_r3_trial_set: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> s_q.trial[s_q.idx]);

    // R3: bits below the trial bit are still zero, so the step halves each time
    a_r3_lower_clear: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> ((s_q.trial & ((NBITS'(1) << s_q.idx) - NBITS'(1))) == '0));

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int NBITS      = 12,
    parameter int ACQ_CYCLES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             cmp_hi,
    output logic             sampling,
    output logic             converting,
    output logic [NBITS-1:0] dac_code,
    output logic             bit_out,
    output logic             bit_vld,
    output logic [NBITS-1:0] result,
    output logic             done
);
    ctl_s c_d, c_q;
    logic fall, start, expire, last;
    logic run, init, step;

    sar_cs_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .fall  (fall)
    );

    sar_acq_timer #(.ACQ_CYCLES(ACQ_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start),
        .run    (run),
        .expire (expire)
    );

    sar_search #(.NBITS(NBITS)) u_search (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .init     (init),
        .step     (step),
        .cmp_hi   (cmp_hi),
        .dac_code (dac_code),
        .bit_out  (bit_out),
        .bit_vld  (bit_vld),
        .result   (result),
        .last     (last)
    );

    assign start = fall && (c_q.ph == PH_IDLE);
    assign run   = (c_q.ph == PH_ACQ) && !cs_n;
    assign init  = run && expire;
    assign step  = (c_q.ph == PH_CONV) && !cs_n;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        unique case (c_q.ph)
            PH_IDLE: if (start) c_d.ph = PH_ACQ;
            PH_ACQ: begin
                if (cs_n)        c_d.ph = PH_IDLE;
                else if (expire) c_d.ph = PH_CONV;
            end
            PH_CONV: begin
                if (cs_n) c_d.ph = PH_IDLE;
                else if (last) begin
                    c_d.ph   = PH_HOLD;
                    c_d.done = 1'b1;
                end
            end
            PH_HOLD: if (cs_n) c_d.ph = PH_IDLE;
            default: c_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{ph: PH_IDLE, done: 1'b0};
        else        c_q <= c_d;
    end

    assign sampling   = (c_q.ph == PH_ACQ);
    assign converting = (c_q.ph == PH_CONV);
    assign done       = c_q.done;

    // R6: the completion pulse lasts one cycle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: completion coincides with the last streamed bit
    a_r6_done_with_bit: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> bit_vld);

    // R2: conversion is always entered from the sampling window
    a_r2_acq_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(converting) |-> $past(sampling));

    // R7: chip select high forces idle on the next cycle
    a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!sampling && !converting));

    // R9: with chip select still low, completion is not followed by a new window
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cs_n) |=> !sampling);

endmodule

// File: tb/sim_sar_conv_seq.sv
`timescale 1ns/1ps
module sim_sar_conv_seq;
    localparam int ACQ = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    // 12-bit unit
    logic        cs0 = 1'b1;
    logic [11:0] held0 = '0;
    logic        cmp0, samp0, conv0, bit0, vld0, done0;
    logic [11:0] dac0, res0;
    assign cmp0 = ($signed(held0) >= $signed(dac0));

    sar_conv_seq #(.NBITS(12), .ACQ_CYCLES(ACQ)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs0), .cmp_hi(cmp0),
        .sampling(samp0), .converting(conv0), .dac_code(dac0),
        .bit_out(bit0), .bit_vld(vld0), .result(res0), .done(done0)
    );

    // 10-bit unit
    logic       cs1 = 1'b1;
    logic [9:0] held1 = '0;
    logic       cmp1, samp1, conv1, bit1, vld1, done1;
    logic [9:0] dac1, res1;
    assign cmp1 = ($signed(held1) >= $signed(dac1));

    sar_conv_seq #(.NBITS(10), .ACQ_CYCLES(ACQ)) u1 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs1), .cmp_hi(cmp1),
        .sampling(samp1), .converting(conv1), .dac_code(dac1),
        .bit_out(bit1), .bit_vld(vld1), .result(res1), .done(done1)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        chk(!samp0 && !conv0, "R1 phase outputs", {samp0, conv0}, 0);
        chk(!done0 && !vld0, "R1 done/bit_vld", {done0, vld0}, 0);
        chk(res0 == 12'h000, "R1 result", res0, 0);
    endtask

    task automatic t_full(input logic [11:0] v);
        int cyc = 0, ns = 0, nb = 0, nc = 0, nd = 0, dcyc = -1;
        logic [11:0] bits = '0, t1 = '0, t2 = '0;
        held0 = v;
        @(negedge clk) cs0 = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            cyc++;
            if (samp0) ns++;
            if (conv0) begin
                nc++;
                if (nc == 1) t1 = dac0;
                if (nc == 2) t2 = dac0;
            end
            if (vld0) begin
                bits = {bits[10:0], bit0};
                nb++;
            end
            if (done0) begin
                nd++;
                if (dcyc < 0) dcyc = cyc;
            end
        end
        chk(ns == ACQ, "R2 sampling length", ns, ACQ);
        chk(t1 == 12'h000, "R3 first trial", t1, 0);
        chk(t2 == (v[11] ? 12'hC00 : 12'h400), "R3 second trial", t2, v[11] ? 12'hC00 : 12'h400);
        chk(res0 == v, "R4 result", res0, v);
        chk(nb == 12 && bits == v, "R5 serial bits", bits, v);
        chk(dcyc == ACQ + 13, "R6 done cycle", dcyc, ACQ + 13);
        chk(nd == 1, "R9 single done with cs held low", nd, 1);
        cs0 = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_abort(input logic [11:0] v, input int k);
        int nb = 0, nd = 0;
        logic [11:0] exp;
        held0 = v;
        exp = v & ~((12'd1 << (12 - k)) - 12'd1);
        @(negedge clk) cs0 = 1'b0;
        for (int i = 0; i < 40 && nb < k; i++) begin
            @(negedge clk);
            if (vld0) nb++;
        end
        cs0 = 1'b1;
        @(negedge clk);
        chk(!samp0 && !conv0, "R7 idle after abort", {samp0, conv0}, 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (done0) nd++;
        end
        chk(nd == 0, "R7 no done after abort", nd, 0);
        chk(res0 == exp, "R8 partial result", res0, exp);
    endtask

    task automatic t_abort_acq();
        int nd = 0;
        held0 = 12'h6B1;
        @(negedge clk) cs0 = 1'b0;
        @(negedge clk);
        chk(samp0, "R2 sampling started", samp0, 1);
        cs0 = 1'b1;
        @(negedge clk);
        chk(!samp0 && !conv0, "R7 idle after acquisition abort", {samp0, conv0}, 0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (done0 || vld0) nd++;
        end
        chk(nd == 0, "R11 no activity after acquisition abort", nd, 0);
        chk(res0 == 12'h000, "R11 result cleared", res0, 0);
    endtask

    task automatic t_hold_restart();
        int ns = 0;
        held0 = 12'h123;
        @(negedge clk) cs0 = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (samp0) ns++;
        end
        chk(ns == ACQ, "R9 no restart while held low", ns, ACQ);
        held0 = 12'hEDC;
        cs0 = 1'b1;
        @(negedge clk);
        cs0 = 1'b0;
        for (int i = 0; i < 30; i++) @(negedge clk);
        chk(res0 == 12'hEDC, "R9 restart after high-low", res0, 12'hEDC);
        cs0 = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_ten(input logic [9:0] v);
        int cyc = 0, nb = 0, dcyc = -1;
        logic [9:0] bits = '0;
        held1 = v;
        @(negedge clk) cs1 = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            cyc++;
            if (vld1) begin
                bits = {bits[8:0], bit1};
                nb++;
            end
            if (done1 && dcyc < 0) dcyc = cyc;
        end
        chk(res1 == v, "R10 10-bit result", res1, v);
        chk(nb == 10 && bits == v, "R10 10-bit serial bits", bits, v);
        chk(dcyc == ACQ + 11, "R10 10-bit done cycle", dcyc, ACQ + 11);
        cs1 = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full(12'h5A3);
        t_full(12'h800);
        t_full(12'h7FF);
        t_full(12'h000);
        t_full(12'hFFF);
        t_full(12'hB2E);
        t_abort_acq();
        t_abort(12'h5A3, 5);
        t_full(12'h3C7);
        t_abort(12'hB2E, 1);
        t_abort(12'h7FF, 11);
        t_hold_restart();
        t_ten(10'h200);
        t_ten(10'h1FF);
        t_ten(10'h2D5);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule